// File: doc/BRIEF.md
# Two-Port Byte Mailbox for a Command Coprocessor

This block is the device-facing register front of a small command coprocessor. A host reaches it through two byte-wide ports selected by one address bit: offset 0 carries payload bytes in both directions, and offset 1 returns a status byte on read and takes a command byte on write. One inbound latch holds the byte the host last wrote, and an internal consumer drains it over a valid/ready stream. One outbound latch holds the next response byte, and an internal producer fills it over a second valid/ready stream.

A transaction runs as follows. The host writes the normal-mode command and waits for the data-ready flag. It streams payload bytes, each written only after the input-full flag has dropped. It then writes end-of-command. The producer answers with a frame: an opening marker byte tagged by the marker flag, untagged payload bytes, and a closing marker byte. Loading the closing marker returns the block to idle. A cancel command resets the exchange from any state and restores command-ready. The consumer tells commands from payload by a tag bit that records which port the last accepted write used.

Top module: `mbx_port`

## Requirements
- R1: Address 0 is the data port and address 1 is status (read) / command (write). The status byte is {2'b00, data_ready[5], cmd_ready[4], cmd_tag[3], marker[2], in_full[1], out_full[0]}. cmd_ready and data_ready are never set together.
- R2: After reset the status byte reads 8'h10, the consumer stream is not valid and the producer stream is ready.
- R3: Command 8'h01 written in idle with in_full clear is latched and forwarded to the consumer with the command tag set. On the next cycle in_full=1, cmd_tag=1, cmd_ready=0 and data_ready=1.
- R4: A data-port write is accepted only while data_ready=1 and in_full=0. When accepted, it sets in_full and clears cmd_tag. Otherwise it leaves the status and the consumer stream unchanged.
- R5: The consumer valid follows in_full and holds a stable byte until it is taken. A taken byte clears in_full on the next cycle. While in_full=1, every write except cancel is ignored.
- R6: Command 8'h03 is accepted only while data_ready=1. It is forwarded with the tag set, and it clears data_ready while cmd_ready stays 0.
- R7: While out_full=0, the producer is ready. A producer byte loads on the next edge, setting out_full, and marker takes the producer's marker bit.
- R8: A data-port read returns the outbound latch. A data-port read with out_full=1 clears out_full and marker on the next edge, and a waiting producer byte loads one edge later. Reading status has no side effect.
- R9: After end-of-command, loading a producer byte 8'h03 with its marker bit set makes cmd_ready read 1.
- R10: Command 8'h22 from any state clears in_full, out_full, marker and data_ready and sets cmd_ready on the next cycle. The producer is not accepted in the cycle the cancel is written.
- R11: Command values other than 8'h01, 8'h03 and 8'h22 are ignored. 8'h01 outside idle and 8'h03 outside the receive phase are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Port select: 0 data, 1 status/command |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Outbound latch or status, chosen by host_sel |
| cons_valid | output | 1 | Inbound byte available to the consumer |
| cons_ready | input | 1 | Consumer takes the inbound byte |
| cons_data | output | DATA_W | Inbound byte |
| cons_is_cmd | output | 1 | Inbound byte came from the command port |
| prod_valid | input | 1 | Producer offers a response byte |
| prod_ready | output | 1 | Outbound latch can take a byte |
| prod_data | input | DATA_W | Response byte |
| prod_mark | input | 1 | Response byte is a frame marker |

## Verification
On every cycle, the assertions check the port-level flag rules. Cancel recovers command-ready and empties both latches. A taken inbound byte clears the valid, and an untaken one stays stable. A producer handshake fills the outbound latch, and a data read empties it. Marker never shows without out_full, and the two ready flags are exclusive. Only the bench's scenarios show the mode sequence: normal, payload, end, framed response, return to idle. They also show which writes are ignored in each mode, the exact byte values on both streams, and the one-cycle gap before a waiting producer byte reloads after a read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int STATUS_W = 8;

    localparam logic [7:0] CMD_NORMAL = 8'h01;
    localparam logic [7:0] CMD_EOC    = 8'h03;
    localparam logic [7:0] CMD_CANCEL = 8'h22;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_RECV = 2'd1,
        MODE_BUSY = 2'd2
    } mode_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       data_rdy;
        logic       cmd_rdy;
        logic       cmd_tag;
        logic       mark;
        logic       in_full;
        logic       out_full;
    } status_t;

    typedef struct packed {
        logic data_wr;
        logic norm;
        logic eoc;
        logic cancel;
        logic data_rd;
    } host_ev_t;

    function automatic status_t build_status(input mode_e mode, input logic tag,
                                             input logic mark, input logic ifull,
                                             input logic ofull);
        status_t s;
        s.rsvd     = 2'b00;
        s.data_rdy = (mode == MODE_RECV);
        s.cmd_rdy  = (mode == MODE_IDLE);
        s.cmd_tag  = tag;
        s.mark     = mark;
        s.in_full  = ifull;
        s.out_full = ofull;
        return s;
    endfunction

endpackage

// File: rtl/mbx_host_decode.sv
module mbx_host_decode
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    input  mode_e             mode,
    input  logic              in_full,
    output host_ev_t          ev
);
    logic cmd_wr;
    logic dat_wr;

    always_comb begin
        cmd_wr     = host_wr && host_sel;
        dat_wr     = host_wr && !host_sel;
        ev.cancel  = cmd_wr && (host_wdata == DATA_W'(CMD_CANCEL));
        ev.norm    = cmd_wr && !in_full && (mode == MODE_IDLE)
                     && (host_wdata == DATA_W'(CMD_NORMAL));
        ev.eoc     = cmd_wr && !in_full && (mode == MODE_RECV)
                     && (host_wdata == DATA_W'(CMD_EOC));
        ev.data_wr = dat_wr && !in_full && (mode == MODE_RECV);
        ev.data_rd = host_rd && !host_sel;
    end
endmodule

// File: rtl/mbx_inbound.sv
module mbx_inbound
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  host_ev_t          ev,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cons_ready,
    output logic              in_full,
    output logic              cmd_tag,
    output logic [DATA_W-1:0] in_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_full <= 1'b0;
            cmd_tag <= 1'b0;
            in_byte <= '0;
        end else if (ev.cancel) begin
            in_full <= 1'b0;
        end else if (ev.norm || ev.eoc) begin
            in_full <= 1'b1;
            cmd_tag <= 1'b1;
            in_byte <= host_wdata;
        end else if (ev.data_wr) begin
            in_full <= 1'b1;
            cmd_tag <= 1'b0;
            in_byte <= host_wdata;
        end else if (in_full && cons_ready) begin
            in_full <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_outbound.sv
module mbx_outbound
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  host_ev_t          ev,
    input  logic              prod_valid,
    input  logic [DATA_W-1:0] prod_data,
    input  logic              prod_mark,
    output logic              prod_ready,
    output logic              load,
    output logic              out_full,
    output logic              mark,
    output logic [DATA_W-1:0] out_byte
);
    assign prod_ready = !out_full && !ev.cancel;
    assign load       = prod_valid && prod_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_full <= 1'b0;
            mark     <= 1'b0;
            out_byte <= '0;
        end else if (ev.cancel) begin
            out_full <= 1'b0;
            mark     <= 1'b0;
        end else if (ev.data_rd && out_full) begin
            out_full <= 1'b0;
            mark     <= 1'b0;
        end else if (load) begin
            out_full <= 1'b1;
            mark     <= prod_mark;
            out_byte <= prod_data;
        end
    end
endmodule

// File: rtl/mbx_mode_fsm.sv
module mbx_mode_fsm
    import mbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_ev_t ev,
    input  logic     end_seen,
    output mode_e    mode
);
    mode_e mode_nx;

    always_comb begin
        mode_nx = mode;
        if (ev.cancel) begin
            mode_nx = MODE_IDLE;
        end else begin
            unique case (mode)
                MODE_IDLE: if (ev.norm) mode_nx = MODE_RECV;
                MODE_RECV: if (ev.eoc) mode_nx = MODE_BUSY;
                MODE_BUSY: if (end_seen) mode_nx = MODE_IDLE;
                default:   mode_nx = MODE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_IDLE;
        else     mode <= mode_nx;
    end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              cons_valid,
    input  logic              cons_ready,
    output logic [DATA_W-1:0] cons_data,
    output logic              cons_is_cmd,
    input  logic              prod_valid,
    output logic              prod_ready,
    input  logic [DATA_W-1:0] prod_data,
    input  logic              prod_mark
);
    host_ev_t          ev;
    mode_e             mode;
    logic              in_full;
    logic              cmd_tag;
    logic [DATA_W-1:0] in_byte;
    logic              ob_load;
    logic              out_full;
    logic              ob_mark;
    logic [DATA_W-1:0] out_byte;
    logic              end_seen;
    status_t           status_s;
    logic [STATUS_W-1:0] status_byte;

    mbx_host_decode #(.DATA_W(DATA_W)) u_dec (
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .mode       (mode),
        .in_full    (in_full),
        .ev         (ev)
    );

    mbx_inbound #(.DATA_W(DATA_W)) u_in (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .host_wdata (host_wdata),
        .cons_ready (cons_ready),
        .in_full    (in_full),
        .cmd_tag    (cmd_tag),
        .in_byte    (in_byte)
    );

    mbx_outbound #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .prod_valid (prod_valid),
        .prod_data  (prod_data),
        .prod_mark  (prod_mark),
        .prod_ready (prod_ready),
        .load       (ob_load),
        .out_full   (out_full),
        .mark       (ob_mark),
        .out_byte   (out_byte)
    );

    assign end_seen = ob_load && prod_mark && (prod_data == DATA_W'(CMD_EOC));

    mbx_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .end_seen (end_seen),
        .mode     (mode)
    );

    always_comb begin
        status_s    = build_status(mode, cmd_tag, ob_mark, in_full, out_full);
        status_byte = status_s;
        host_rdata  = host_sel ? DATA_W'(status_byte) : out_byte;
    end

    assign cons_valid  = in_full;
    assign cons_data   = in_byte;
    assign cons_is_cmd = cmd_tag;
endmodule

// File: rtl/mbx_port_checker.sv
module mbx_port_checker
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              host_sel,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_wdata,
    input logic              cons_valid,
    input logic              cons_ready,
    input logic [DATA_W-1:0] cons_data,
    input logic              prod_valid,
    input logic              prod_ready,
    input logic [7:0]        status
);
    logic cancel_wr;
    assign cancel_wr = host_wr && host_sel && (host_wdata == DATA_W'(CMD_CANCEL));

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(status[4] && status[5]));                                        // R1
    AST_CANCEL_RECOVERS: assert property (@(posedge clk) disable iff (rst)
        cancel_wr |=> status[4] && !status[5] && !status[0] && !status[1] && !status[2]); // R10
    AST_CANCEL_BLOCKS_PROD: assert property (@(posedge clk) disable iff (rst)
        cancel_wr |-> !prod_ready);                                        // R10
    AST_MARK_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        status[2] |-> status[0]);                                          // R7
    AST_PROD_FILLS: assert property (@(posedge clk) disable iff (rst)
        prod_valid && prod_ready |=> status[0]);                           // R7
    AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cons_valid && cons_ready |=> !cons_valid);                         // R5
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        cons_valid && !cons_ready && !cancel_wr |=> cons_valid && $stable(cons_data)); // R5
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        host_rd && !host_sel && !host_wr && status[0] |=> !status[0]);     // R8
    AST_DATA_IGNORED: assert property (@(posedge clk) disable iff (rst)
        host_wr && !host_sel && !status[5] && !status[1] |=> !cons_valid);  // R4
endmodule

bind mbx_port mbx_port_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .cons_valid (cons_valid),
    .cons_ready (cons_ready),
    .cons_data  (cons_data),
    .prod_valid (prod_valid),
    .prod_ready (prod_ready),
    .status     (status_byte)
);

// File: tb/sim_mbx_port.sv
`timescale 1ns/1ps
module sim_mbx_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_sel = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       cons_valid;
    logic       cons_ready = 1'b0;
    logic [7:0] cons_data;
    logic       cons_is_cmd;
    logic       prod_valid = 1'b0;
    logic       prod_ready;
    logic [7:0] prod_data = 8'h00;
    logic       prod_mark = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mbx_port #(.DATA_W(8)) u0 (.*);

    // op: 0 command write, 1 data write, 2 consumer take, 3 producer push, 4 data read
    // fields: {op[2:0], flag, byte, expected status, expected aux}
    localparam int NV = 17;
    localparam logic [27:0] VEC [NV] = '{
        {3'd0, 1'b0, 8'h01, 8'h2A, 8'h00},  // R3 normal in idle
        {3'd2, 1'b1, 8'h00, 8'h28, 8'h01},  // R3 forwarded as command
        {3'd1, 1'b0, 8'hA5, 8'h22, 8'h00},  // R4 payload accepted
        {3'd2, 1'b0, 8'h00, 8'h20, 8'hA5},  // R5 take clears in_full
        {3'd1, 1'b0, 8'h3C, 8'h22, 8'h00},  // R4
        {3'd1, 1'b0, 8'h77, 8'h22, 8'h00},  // R5 write while full ignored
        {3'd2, 1'b0, 8'h00, 8'h20, 8'h3C},  // R5 held byte intact
        {3'd0, 1'b0, 8'h55, 8'h20, 8'h00},  // R11 unknown command
        {3'd0, 1'b0, 8'h03, 8'h0A, 8'h00},  // R6 end of command
        {3'd2, 1'b1, 8'h00, 8'h08, 8'h03},  // R6 forwarded as command
        {3'd1, 1'b0, 8'h11, 8'h08, 8'h00},  // R4 data in busy ignored
        {3'd3, 1'b1, 8'h01, 8'h0D, 8'h00},  // R7 opening marker
        {3'd4, 1'b0, 8'h00, 8'h08, 8'h01},  // R8 read clears
        {3'd3, 1'b0, 8'h9E, 8'h09, 8'h00},  // R7 payload, marker clear
        {3'd4, 1'b0, 8'h00, 8'h08, 8'h9E},  // R8
        {3'd3, 1'b1, 8'h03, 8'h1D, 8'h00},  // R9 closing marker -> ready
        {3'd4, 1'b0, 8'h00, 8'h18, 8'h03}   // R8
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic get_status(output logic [7:0] s);
        host_sel = 1'b1;
        #1 s = host_rdata;
    endtask

    task automatic host_write(input logic sel, input logic [7:0] val);
        @(negedge clk);
        host_sel = sel; host_wdata = val; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic data_read(output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic cons_take(input logic [7:0] exp_d, input logic exp_cmd);
        @(negedge clk);
        #1;
        check(cons_valid === 1'b1, "R5 valid", int'(cons_valid), 1);
        check(cons_data === exp_d, "R5 data", int'(cons_data), int'(exp_d));
        check(cons_is_cmd === exp_cmd, "R3 tag", int'(cons_is_cmd), int'(exp_cmd));
        cons_ready = 1'b1;
        @(negedge clk);
        cons_ready = 1'b0;
    endtask

    task automatic prod_push(input logic [7:0] d, input logic m);
        @(negedge clk);
        prod_valid = 1'b1; prod_data = d; prod_mark = m;
        #1 check(prod_ready === 1'b1, "R7 ready", int'(prod_ready), 1);
        @(negedge clk);
        prod_valid = 1'b0;
    endtask

    initial begin
        repeat (400) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] s;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        get_status(s);
        check(s === 8'h10, "R2 status", int'(s), 8'h10);
        check(cons_valid === 1'b0, "R2 cons_valid", int'(cons_valid), 0);
        check(prod_ready === 1'b1, "R2 prod_ready", int'(prod_ready), 1);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            logic       fl;
            logic [7:0] by, es, ea;
            {op, fl, by, es, ea} = VEC[i];
            case (op)
                3'd0: host_write(1'b1, by);
                3'd1: host_write(1'b0, by);
                3'd2: cons_take(ea, fl);
                3'd3: prod_push(by, fl);
                default: begin
                    data_read(d);
                    check(d === ea, "R8 read byte", int'(d), int'(ea));
                end
            endcase
            get_status(s);
            check(s === es, "R1 status after step", int'(s), int'(es));
        end

        // R8: status read has no side effect
        prod_push(8'h42, 1'b0);
        @(negedge clk);
        host_sel = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        get_status(s);
        check(s === 8'h19, "R8 status read keeps latch", int'(s), 8'h19);

        // R8: waiting producer byte loads one edge after the read edge
        @(negedge clk);
        prod_valid = 1'b1; prod_data = 8'h66; prod_mark = 1'b0;
        host_sel = 1'b0; host_rd = 1'b1;
        #1 check(host_rdata === 8'h42, "R8 read value", int'(host_rdata), 8'h42);
        @(negedge clk);
        host_rd = 1'b0;
        get_status(s);
        check(s[0] === 1'b0, "R8 emptied after read", int'(s[0]), 0);
        check(prod_ready === 1'b1, "R8 ready after read", int'(prod_ready), 1);
        @(negedge clk);
        prod_valid = 1'b0;
        get_status(s);
        check(s === 8'h19, "R8 reload status", int'(s), 8'h19);
        host_sel = 1'b0;
        #1 check(host_rdata === 8'h66, "R8 reload byte", int'(host_rdata), 8'h66);

        // R10: cancel from receive with both latches full
        host_write(1'b1, 8'h01);
        get_status(s);
        check(s === 8'h2B, "R3 normal with out_full", int'(s), 8'h2B);
        @(negedge clk);
        prod_valid = 1'b1; prod_data = 8'h77; prod_mark = 1'b1;
        host_sel = 1'b1; host_wdata = 8'h22; host_wr = 1'b1;
        #1 check(prod_ready === 1'b0, "R10 producer blocked", int'(prod_ready), 0);
        @(negedge clk);
        host_wr = 1'b0; prod_valid = 1'b0;
        get_status(s);
        check(s === 8'h18, "R10 status after cancel", int'(s), 8'h18);
        check(cons_valid === 1'b0, "R10 consumer cleared", int'(cons_valid), 0);

        // R11: end-of-command in idle ignored
        host_write(1'b1, 8'h03);
        get_status(s);
        check(s === 8'h18, "R11 eoc in idle", int'(s), 8'h18);
        check(cons_valid === 1'b0, "R11 eoc not forwarded", int'(cons_valid), 0);

        // R11: normal while receiving ignored
        host_write(1'b1, 8'h01);
        cons_take(8'h01, 1'b1);
        host_write(1'b1, 8'h01);
        get_status(s);
        check(s === 8'h28, "R11 normal in receive", int'(s), 8'h28);
        check(cons_valid === 1'b0, "R11 normal not forwarded", int'(cons_valid), 0);

        // R2: reset mid-transaction
        host_write(1'b0, 8'h5A);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        get_status(s);
        check(s === 8'h10, "R2 status after reset", int'(s), 8'h10);
        check(cons_valid === 1'b0, "R2 cons_valid after reset", int'(cons_valid), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule